// File: doc/BRIEF.md
# Floating-Point Conditional Commit Unit

This block decides, one instruction at a time, whether a conditional floating-point operation takes effect. On each clock edge where the valid strobe is high, it evaluates the selected condition code. The code is tested against the current comparison flags (negative, zero, infinity, not-a-number) or, for the error test, against the current exception flags. If the condition holds, the block raises a one-cycle commit pulse and loads its held status registers from the new status that the ALU produced. If the condition does not hold, the status it holds is left untouched.

The ordered-compare tests follow IEEE semantics. A plain ordered test such as "greater than" is false whenever the operand was a NaN. Its negated partner, "not greater than", is the complement of the ordered expression and not of the plain test, so it is true for a NaN. For the IEEE-aware codes, a NaN operand sets a sticky unordered-compare exception bit and a sticky interrupt request. Both stay set until a clear input is pulsed. The block also forwards the register move that goes with the instruction. When no move is given, it substitutes a register-0 to register-0 transfer.

Top module: `fp_cond_commit`

## Requirements
- R1: While `rst_n` is low, and until the first valid edge after reset, `commit_o`, `cond_o`, `exc_o`, `unord_irq_o`, `move_src_o` and `move_dst_o` are all zero.
- R2: Flag bits in `cond_flags_i` are [3]=negative N, [2]=zero Z, [1]=infinity I, [0]=NaN U. Code 2 (GT) is true iff U|Z|N is 0. Code 4 (GE) is true iff U|(N&~Z) is 0. Code 6 (LT) is true iff U|Z|~N is 0. Code 8 (LE) is true iff U|~(N|Z) is 0.
- R3: Codes 3 (NGT), 5 (NGE), 7 (NLT) and 9 (NLE) are true iff the expression of codes 2, 4, 6 and 8 respectively equals 1. Each of them is therefore true when U=1.
- R4: Code 10 (GL) is true iff U|Z is 0, and code 11 (NGL) is its complement. Codes 12 (GLE) and 18 (ordered) are true iff U=0. Codes 13 (NGLE) and 19 (unordered) are true iff U=1.
- R5: Code 0 (EQ) is true iff Z=1, code 1 (NE) iff Z=0, code 14 (MI) iff N=1, code 15 (PL) iff N=0, code 16 (INF) iff I=1, and code 17 (NINF) iff I=0.
- R6: Code 20 (ERR) is true iff any bit of `exc_flags_i` is set, regardless of `cond_flags_i`. The bits of `exc_flags_i` are [5] unordered compare, [4] signalling NaN, [3] invalid operation, [2] overflow, [1] underflow and [0] divide by zero.
- R7: Codes 21 to 31 are false and never set the sticky bits.
- R8: On a valid edge with a true condition, `commit_o` is 1 for the following cycle. `cond_o` takes `new_cond_i`, `exc_o[4:0]` takes `new_exc_i[4:0]`, and `exc_o[5]` becomes its old value OR `new_exc_i[5]`.
- R9: On a valid edge with a false condition, `commit_o` is 0 for the following cycle, and `cond_o` and `exc_o[4:0]` keep their values.
- R10: On a valid edge with U=1 and an IEEE-aware code (2 to 13, 16, 17), `exc_o[5]` and `unord_irq_o` become 1, whether or not the condition is true.
- R11: Codes 0, 1, 14, 15, 18, 19 and 20 never set `exc_o[5]` or `unord_irq_o` on their own, even with U=1.
- R12: `exc_o[5]` and `unord_irq_o` stay set until an edge with `clr_sticky_i` high, which clears them whether or not `valid_i` is high. A set on the same edge wins over the clear.
- R13: On every valid edge, `move_src_o`/`move_dst_o` take `mov_src_i`/`mov_dst_i` when `mov_valid_i` is 1, and both become 0 (register 0 to register 0) when it is 0.
- R14: An edge with `valid_i` low leaves `commit_o` at 0 and leaves every other output unchanged, apart from the clear described in R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| cc_sel_i | input | 5 | Condition code select |
| cond_flags_i | input | 4 | Current N, Z, I, U flags |
| exc_flags_i | input | 6 | Current exception flags |
| new_cond_i | input | 4 | Comparison flags produced by the ALU |
| new_exc_i | input | 6 | Exception flags produced by the ALU |
| mov_valid_i | input | 1 | A register move is specified |
| mov_src_i | input | REG_W | Move source register index |
| mov_dst_i | input | REG_W | Move destination register index |
| clr_sticky_i | input | 1 | Clear the sticky unordered bits |
| commit_o | output | 1 | One-cycle write enable for result, move and status |
| move_src_o | output | REG_W | Effective move source |
| move_dst_o | output | REG_W | Effective move destination |
| cond_o | output | 4 | Held comparison flags |
| exc_o | output | 6 | Held exception flags, bit 5 sticky |
| unord_irq_o | output | 1 | Sticky unordered-compare interrupt request |

## Verification
Every one of the 32 codes is issued under all 16 comparison-flag patterns. These patterns separate plain ordered tests from their negated partners on NaN, and greater from equal from less, and they show whether a code reads the infinity bit at all. The error code is tried with all comparison flags set and no exception, and then with each exception bit alone, which separates the two flag sources. Separate sequences pulse the clear with and without a concurrent NaN set, omit the move, and hold the strobe low while the inputs change.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int CC_W     = 5;
    localparam int CFLAG_W  = 4;
    localparam int EXC_W    = 6;
    localparam int NUM_PAIR = 10;

    // comparison flag bit positions
    localparam int FL_N   = 3;
    localparam int FL_Z   = 2;
    localparam int FL_I   = 1;
    localparam int FL_U   = 0;

    // exception flag bit position of the sticky unordered-compare bit
    localparam int EX_UNORD = 5;

    // even code = plain test (expression == 0), odd code = negated test
    typedef enum logic [CC_W-1:0] {
        CC_EQ   = 5'd0,  CC_NE   = 5'd1,
        CC_GT   = 5'd2,  CC_NGT  = 5'd3,
        CC_GE   = 5'd4,  CC_NGE  = 5'd5,
        CC_LT   = 5'd6,  CC_NLT  = 5'd7,
        CC_LE   = 5'd8,  CC_NLE  = 5'd9,
        CC_GL   = 5'd10, CC_NGL  = 5'd11,
        CC_GLE  = 5'd12, CC_NGLE = 5'd13,
        CC_MI   = 5'd14, CC_PL   = 5'd15,
        CC_INF  = 5'd16, CC_NINF = 5'd17,
        CC_ORD  = 5'd18, CC_UNO  = 5'd19,
        CC_ERR  = 5'd20
    } fpcc_code_e;

endpackage

// File: rtl/fpcc_cond_eval.sv
module fpcc_cond_eval
    import fpcc_pkg::*;
(
    input  logic [CC_W-1:0]    cc_sel_i,
    input  logic [CFLAG_W-1:0] cond_flags_i,
    input  logic [EXC_W-1:0]   exc_flags_i,
    output logic               truth_o
);

    localparam int IDX_W = CC_W - 1;

    logic [(1<<IDX_W)-1:0] pair_expr;
    logic [IDX_W-1:0]      pair_idx;
    logic                  n, z, i, u;

    assign n        = cond_flags_i[FL_N];
    assign z        = cond_flags_i[FL_Z];
    assign i        = cond_flags_i[FL_I];
    assign u        = cond_flags_i[FL_U];
    assign pair_idx = cc_sel_i[CC_W-1:1];

    // one expression per pair; the plain code is true when it is 0
    always_comb begin
        pair_expr     = '0;
        pair_expr[0]  = ~z;
        pair_expr[1]  = u | z | n;
        pair_expr[2]  = u | (n & ~z);
        pair_expr[3]  = u | z | ~n;
        pair_expr[4]  = u | ~(n | z);
        pair_expr[5]  = u | z;
        pair_expr[6]  = u;
        pair_expr[7]  = ~n;
        pair_expr[8]  = ~i;
        pair_expr[9]  = u;
    end

    always_comb begin
        if (cc_sel_i < CC_W'(2 * NUM_PAIR)) begin
            truth_o = cc_sel_i[0] ? pair_expr[pair_idx] : ~pair_expr[pair_idx];
        end else if (cc_sel_i == CC_ERR) begin
            truth_o = |exc_flags_i;
        end else begin
            truth_o = 1'b0;
        end
    end

endmodule

// File: rtl/fpcc_aware_decode.sv
module fpcc_aware_decode
    import fpcc_pkg::*;
(
    input  logic [CC_W-1:0] cc_sel_i,
    output logic            aware_o
);

    always_comb begin
        unique case (cc_sel_i)
            CC_GT, CC_NGT, CC_GE, CC_NGE, CC_LT, CC_NLT,
            CC_LE, CC_NLE, CC_GL, CC_NGL, CC_GLE, CC_NGLE,
            CC_INF, CC_NINF: aware_o = 1'b1;
            default:         aware_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpcc_move_sel.sv
module fpcc_move_sel #(
    parameter int REG_W = 3
) (
    input  logic             mov_valid_i,
    input  logic [REG_W-1:0] mov_src_i,
    input  logic [REG_W-1:0] mov_dst_i,
    output logic [REG_W-1:0] src_o,
    output logic [REG_W-1:0] dst_o
);

    // an absent move becomes register 0 copied onto itself
    assign src_o = mov_valid_i ? mov_src_i : '0;
    assign dst_o = mov_valid_i ? mov_dst_i : '0;

endmodule

// File: rtl/fp_cond_commit.sv
module fp_cond_commit
    import fpcc_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [CC_W-1:0]     cc_sel_i,
    input  logic [CFLAG_W-1:0]  cond_flags_i,
    input  logic [EXC_W-1:0]    exc_flags_i,
    input  logic [CFLAG_W-1:0]  new_cond_i,
    input  logic [EXC_W-1:0]    new_exc_i,
    input  logic                mov_valid_i,
    input  logic [REG_W-1:0]    mov_src_i,
    input  logic [REG_W-1:0]    mov_dst_i,
    input  logic                clr_sticky_i,
    output logic                commit_o,
    output logic [REG_W-1:0]    move_src_o,
    output logic [REG_W-1:0]    move_dst_o,
    output logic [CFLAG_W-1:0]  cond_o,
    output logic [EXC_W-1:0]    exc_o,
    output logic                unord_irq_o
);

    typedef struct packed {
        logic               commit;
        logic [REG_W-1:0]   src;
        logic [REG_W-1:0]   dst;
        logic [CFLAG_W-1:0] cond;
        logic [EXC_W-1:0]   exc;
        logic               irq;
    } cstate_t;

    cstate_t          st_d, st_q;
    logic             truth;
    logic             aware;
    logic             unord_set;
    logic [REG_W-1:0] src_eff, dst_eff;

    fpcc_cond_eval u_eval (
        .cc_sel_i     (cc_sel_i),
        .cond_flags_i (cond_flags_i),
        .exc_flags_i  (exc_flags_i),
        .truth_o      (truth)
    );

    fpcc_aware_decode u_aware (
        .cc_sel_i (cc_sel_i),
        .aware_o  (aware)
    );

    fpcc_move_sel #(.REG_W(REG_W)) u_move (
        .mov_valid_i (mov_valid_i),
        .mov_src_i   (mov_src_i),
        .mov_dst_i   (mov_dst_i),
        .src_o       (src_eff),
        .dst_o       (dst_eff)
    );

    assign unord_set = valid_i & aware & cond_flags_i[FL_U];

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        // clear first so a set on the same edge wins
        if (clr_sticky_i) begin
            st_d.exc[EX_UNORD] = 1'b0;
            st_d.irq           = 1'b0;
        end
        if (valid_i) begin
            st_d.commit = truth;
            st_d.src    = src_eff;
            st_d.dst    = dst_eff;
            if (truth) begin
                st_d.cond               = new_cond_i;
                st_d.exc[EX_UNORD-1:0]  = new_exc_i[EX_UNORD-1:0];
                st_d.exc[EX_UNORD]      = st_d.exc[EX_UNORD] | new_exc_i[EX_UNORD];
            end
        end
        if (unord_set) begin
            st_d.exc[EX_UNORD] = 1'b1;
            st_d.irq           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o    = st_q.commit;
    assign move_src_o  = st_q.src;
    assign move_dst_o  = st_q.dst;
    assign cond_o      = st_q.cond;
    assign exc_o       = st_q.exc;
    assign unord_irq_o = st_q.irq;

endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker
    import fpcc_pkg::*;
#(
    parameter int REG_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic [CC_W-1:0]     cc_sel_i,
    input logic [CFLAG_W-1:0]  cond_flags_i,
    input logic [EXC_W-1:0]    exc_flags_i,
    input logic [CFLAG_W-1:0]  new_cond_i,
    input logic                mov_valid_i,
    input logic                clr_sticky_i,
    input logic                commit_o,
    input logic [REG_W-1:0]    move_src_o,
    input logic [REG_W-1:0]    move_dst_o,
    input logic [CFLAG_W-1:0]  cond_o,
    input logic [EXC_W-1:0]    exc_o,
    input logic                unord_irq_o
);

    AST_LOAD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> cond_o == $past(new_cond_i)); // R8

    AST_HOLD_WHEN_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> ($stable(cond_o) && $stable(exc_o[EX_UNORD-1:0]))); // R9

    AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> (!commit_o && $stable(move_src_o) && $stable(move_dst_o))); // R14

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(unord_irq_o) && !$past(clr_sticky_i)) |-> unord_irq_o); // R12

    AST_IRQ_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unord_irq_o) |-> ($past(valid_i) && $past(cond_flags_i[FL_U]))); // R10

    AST_UNUSED_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && ($past(cc_sel_i) > CC_ERR)) |-> !commit_o); // R7

    AST_ERR_NEEDS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && ($past(cc_sel_i) == CC_ERR) && ($past(exc_flags_i) == '0))
        |-> !commit_o); // R6

    AST_DEFAULT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && !$past(mov_valid_i)) |-> (move_src_o == '0 && move_dst_o == '0)); // R13

endmodule

bind fp_cond_commit fpcc_checker #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .cc_sel_i     (cc_sel_i),
    .cond_flags_i (cond_flags_i),
    .exc_flags_i  (exc_flags_i),
    .new_cond_i   (new_cond_i),
    .mov_valid_i  (mov_valid_i),
    .clr_sticky_i (clr_sticky_i),
    .commit_o     (commit_o),
    .move_src_o   (move_src_o),
    .move_dst_o   (move_dst_o),
    .cond_o       (cond_o),
    .exc_o        (exc_o),
    .unord_irq_o  (unord_irq_o)
);

// File: tb/tb_fp_cond_commit.sv
module tb_fp_cond_commit;

    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [4:0]    cc_sel_i = '0;
    logic [3:0]    cond_flags_i = '0;
    logic [5:0]    exc_flags_i = '0;
    logic [3:0]    new_cond_i = '0;
    logic [5:0]    new_exc_i = '0;
    logic          mov_valid_i = 1'b0;
    logic [RW-1:0] mov_src_i = '0;
    logic [RW-1:0] mov_dst_i = '0;
    logic          clr_sticky_i = 1'b0;
    logic          commit_o;
    logic [RW-1:0] move_src_o, move_dst_o;
    logic [3:0]    cond_o;
    logic [5:0]    exc_o;
    logic          unord_irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the held state
    logic [3:0]    m_cond = '0;
    logic [5:0]    m_exc = '0;
    logic          m_irq = 1'b0;
    logic [RW-1:0] m_src = '0, m_dst = '0;

    always #4 clk = ~clk; // 125 MHz

    fp_cond_commit #(.REG_W(RW)) dut (
        .clk, .rst_n, .valid_i, .cc_sel_i, .cond_flags_i, .exc_flags_i,
        .new_cond_i, .new_exc_i, .mov_valid_i, .mov_src_i, .mov_dst_i,
        .clr_sticky_i, .commit_o, .move_src_o, .move_dst_o, .cond_o,
        .exc_o, .unord_irq_o
    );

    function automatic logic exp_truth(input int c, input logic [3:0] f, input logic [5:0] e);
        logic n, z, i, u;
        n = f[3]; z = f[2]; i = f[1]; u = f[0];
        case (c)
            0:  return z;
            1:  return !z;
            2:  return !(u || z || n);
            3:  return  (u || z || n);
            4:  return !(u || (n && !z));
            5:  return  (u || (n && !z));
            6:  return !(u || z || !n);
            7:  return  (u || z || !n);
            8:  return !(u || !(n || z));
            9:  return  (u || !(n || z));
            10: return !(u || z);
            11: return  (u || z);
            12: return !u;
            13: return u;
            14: return n;
            15: return !n;
            16: return i;
            17: return !i;
            18: return !u;
            19: return u;
            20: return e != 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_aware(input int c);
        return (c >= 2 && c <= 13) || c == 16 || c == 17;
    endfunction

    function automatic string tag_of(input int c);
        if (c <= 1 || (c >= 14 && c <= 17)) return "R5";
        if (c >= 2 && c <= 9) return (c % 2 == 0) ? "R2" : "R3";
        if (c <= 19) return "R4";
        if (c == 20) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // drive one instruction at a falling edge, check after the next rising edge
    task automatic issue(input int c, input logic [3:0] f, input logic [5:0] e,
                         input logic [3:0] nc, input logic [5:0] ne,
                         input logic mv, input logic [RW-1:0] s, input logic [RW-1:0] d,
                         input logic clr);
        logic t;
        @(negedge clk);
        valid_i = 1'b1; cc_sel_i = 5'(c); cond_flags_i = f; exc_flags_i = e;
        new_cond_i = nc; new_exc_i = ne; mov_valid_i = mv; mov_src_i = s; mov_dst_i = d;
        clr_sticky_i = clr;
        t = exp_truth(c, f, e);
        if (clr) begin m_exc[5] = 1'b0; m_irq = 1'b0; end
        m_src = mv ? s : '0;
        m_dst = mv ? d : '0;
        if (t) begin
            m_cond = nc;
            m_exc  = {m_exc[5] | ne[5], ne[4:0]};
        end
        if (exp_aware(c) && f[0]) begin m_exc[5] = 1'b1; m_irq = 1'b1; end
        @(negedge clk);
        valid_i = 1'b0; clr_sticky_i = 1'b0;
        chk(tag_of(c), "commit", 32'(commit_o), 32'(t));
        chk(t ? "R8" : "R9", "cond_o", 32'(cond_o), 32'(m_cond));
        chk(t ? "R8" : "R9", "exc_o", 32'(exc_o), 32'(m_exc));
        chk(exp_aware(c) ? "R10" : "R11", "unord_irq_o", 32'(unord_irq_o), 32'(m_irq));
        chk("R13", "move", 32'({move_src_o, move_dst_o}), 32'({m_src, m_dst}));
    endtask

    task automatic t_reset;
        chk("R1", "reset commit", 32'(commit_o), 0);
        chk("R1", "reset cond", 32'(cond_o), 0);
        chk("R1", "reset exc", 32'(exc_o), 0);
        chk("R1", "reset irq", 32'(unord_irq_o), 0);
        chk("R1", "reset move", 32'({move_src_o, move_dst_o}), 0);
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 16; f++) begin
                issue(c, 4'(f), 6'(c ^ f), 4'(~f), 6'((c * 7 + f) & 6'h1f),
                      f[0], RW'(c), RW'(f), 1'b1);
            end
        end
    endtask

    task automatic t_err;
        issue(20, 4'hf, 6'h00, 4'h3, 6'h01, 1'b1, 3'd1, 3'd2, 1'b1); // R6 flags ignored
        for (int b = 0; b < 6; b++)
            issue(20, 4'h1, 6'(1 << b), 4'(b), 6'h02, 1'b1, 3'd3, 3'd4, 1'b0); // R6 each bit
        chk("R11", "err with nan leaves irq", 32'(unord_irq_o), 0);
    endtask

    task automatic t_sticky;
        issue(2, 4'h1, 6'h00, 4'h5, 6'h00, 1'b1, 3'd1, 3'd1, 1'b0); // R10 set, false cond
        issue(0, 4'h4, 6'h00, 4'h2, 6'h00, 1'b1, 3'd1, 3'd1, 1'b0); // R12 commit keeps sticky
        chk("R12", "sticky after commit", 32'(exc_o[5]), 1);
        @(negedge clk); clr_sticky_i = 1'b1;                          // R12 clear without valid
        @(negedge clk); clr_sticky_i = 1'b0;
        m_exc[5] = 1'b0; m_irq = 1'b0;
        chk("R12", "clear irq", 32'(unord_irq_o), 0);
        chk("R12", "clear exc", 32'(exc_o), 32'(m_exc));
        issue(13, 4'h1, 6'h00, 4'h0, 6'h00, 1'b0, 3'd0, 3'd0, 1'b0);
        issue(7, 4'h1, 6'h00, 4'h0, 6'h00, 1'b0, 3'd0, 3'd0, 1'b1); // R12 set wins over clear
        chk("R12", "set beats clear", 32'(unord_irq_o), 1);
    endtask

    task automatic t_move;
        issue(1, 4'h0, 6'h00, 4'h8, 6'h04, 1'b1, 3'd5, 3'd6, 1'b0);
        issue(1, 4'h0, 6'h00, 4'h8, 6'h04, 1'b0, 3'd7, 3'd7, 1'b0); // R13 default move
        chk("R13", "default move zero", 32'({move_src_o, move_dst_o}), 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        cc_sel_i = 5'd1; cond_flags_i = 4'h1; new_cond_i = 4'ha; new_exc_i = 6'h3f;
        mov_valid_i = 1'b1; mov_src_i = 3'd2; mov_dst_i = 3'd3;
        repeat (2) @(negedge clk);
        chk("R14", "idle commit", 32'(commit_o), 0);
        chk("R14", "idle cond", 32'(cond_o), 32'(m_cond));
        chk("R14", "idle exc", 32'(exc_o), 32'(m_exc));
        chk("R14", "idle irq", 32'(unord_irq_o), 32'(m_irq));
        chk("R14", "idle move", 32'({move_src_o, move_dst_o}), 32'({m_src, m_dst}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_sweep;
        t_err;
        t_sticky;
        t_move;
        t_idle;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule